// File: doc/BRIEF.md
# Guarded Access Ordering Queue

This block is a small in-order holding buffer placed between a load/store unit and a memory bus. Each request is a load, a store or a barrier. Loads and stores carry a guarded flag, which marks device or uncached space with strict ordering needs, plus an address and a tag. The block holds up to DEPTH requests. Every cycle it offers the bus the oldest request that the ordering rules let go, so a load can slip past a stalled store when that is safe.

The bus side has two lanes with separate ready inputs, one for loads and one for stores. An operation is offered only when its lane is ready, and an offered operation is taken in the same cycle. This lets the write path stall while reads keep flowing, and that stall is the situation where the passing rules matter. Barriers never reach the bus. A barrier stays in the queue as a fence against younger guarded loads. It leaves the queue once every guarded store ahead of it has gone.

Top module: `guarded_order_queue`

## Requirements
- R1: After reset the queue is empty: `req_ready` is 1 and `bus_valid` is 0.
- R2: `req_kind` encodes 0 = load, 1 = store, 2 = barrier. A request is accepted when `req_valid` and `req_ready` are both high. The queue holds DEPTH (default 8) requests, and `req_ready` is 0 while it is full.
- R3: A guarded load never issues ahead of an older guarded load.
- R4: Stores issue in arrival order.
- R5: No store, guarded or ordinary, issues while an older load is still queued.
- R6: A load may issue ahead of an older store when their 8-byte granules differ, meaning address bits [AW-1:3] differ. Among the requests allowed to go, the oldest goes first.
- R7: A load whose granule matches that of an older queued store waits until that store has issued.
- R8: A barrier never appears on the bus. While a barrier is queued, every younger guarded load waits, even on a different granule. The barrier retires once no older guarded store remains.
- R9: One barrier placed after a group of guarded stores holds later guarded loads until the whole group has issued.
- R10: An ordinary (non-guarded) load is not held back by barriers or by older loads. It may pass a blocked guarded load.
- R11: A load is offered only while `bus_ld_ready` is 1, and a store only while `bus_st_ready` is 1. An offered operation is taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Queue can accept a request |
| req_kind | input | 2 | 0 load, 1 store, 2 barrier |
| req_guarded | input | 1 | Guarded/uncached access |
| req_addr | input | AW | Byte address |
| req_tag | input | TW | Request tag |
| bus_ld_ready | input | 1 | Bus can take a load this cycle |
| bus_st_ready | input | 1 | Bus can take a store this cycle |
| bus_valid | output | 1 | Operation issued this cycle |
| bus_store | output | 1 | Issued operation is a store |
| bus_guarded | output | 1 | Issued operation is guarded |
| bus_addr | output | AW | Issued address |
| bus_tag | output | TW | Issued tag |

## Verification
The queue is filled while both lanes are stalled. Then only the load lane is opened, and later both lanes. In each phase the bench checks the issue order and the number of operations issued. One pattern mixes guarded stores with guarded loads on the same and on different granules, which separates legal passing from overlap stalls and from the order among guarded loads. A second pattern places a barrier behind a group of guarded stores, with a guarded load and an ordinary load after it. This shows that the barrier fences only guarded loads and never reaches the bus. Further patterns cover stores waiting behind older loads, stores leaving in arrival order, and a full queue that backpressures a ninth request.

// File: rtl/guarded_order_queue.sv
module guarded_order_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic          req_guarded,
  input  logic [AW-1:0] req_addr,
  input  logic [TW-1:0] req_tag,
  input  logic          bus_ld_ready,
  input  logic          bus_st_ready,
  output logic          bus_valid,
  output logic          bus_store,
  output logic          bus_guarded,
  output logic [AW-1:0] bus_addr,
  output logic [TW-1:0] bus_tag
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam logic [1:0] K_LD = 2'd0;
  localparam logic [1:0] K_ST = 2'd1;
  localparam logic [1:0] K_BAR = 2'd2;

  logic [1:0]    kd [DEPTH];
  logic          gd [DEPTH];
  logic [AW-1:0] ad [DEPTH];
  logic [TW-1:0] tg [DEPTH];
  logic [1:0]    kd_n [DEPTH];
  logic          gd_n [DEPTH];
  logic [AW-1:0] ad_n [DEPTH];
  logic [TW-1:0] tg_n [DEPTH];
  logic [CW-1:0] cnt, cnt_n, wi;
  logic [DEPTH-1:0] elig;
  logic [IW-1:0] pick;
  logic hit, pop, push;

  always_comb begin
    logic ok, ovl, lane;
    for (int i = 0; i < DEPTH; i++) begin
      ok = 1'b1;
      for (int j = 0; j < i; j++) begin
        ovl = ad[i][AW-1:3] == ad[j][AW-1:3];
        case (kd[i])
          K_LD: begin
            if (kd[j] == K_ST && ovl) ok = 1'b0;
            if (gd[i] && kd[j] == K_LD && gd[j]) ok = 1'b0;
            if (gd[i] && kd[j] == K_BAR) ok = 1'b0;
          end
          K_ST: if (kd[j] != K_BAR) ok = 1'b0;
          default: if (kd[j] == K_ST && gd[j]) ok = 1'b0;
        endcase
      end
      lane = (kd[i] == K_LD) ? bus_ld_ready : (kd[i] == K_ST) ? bus_st_ready : 1'b1;
      elig[i] = (CW'(i) < cnt) && ok && lane;
    end
  end

  always_comb begin
    hit = 1'b0;
    pick = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (elig[i]) begin
        hit = 1'b1;
        pick = IW'(i);
      end
  end

  assign pop         = hit;
  assign push        = req_valid && req_ready;
  assign req_ready   = cnt != CW'(DEPTH);
  assign bus_valid   = hit && kd[pick] != K_BAR;
  assign bus_store   = kd[pick] == K_ST;
  assign bus_guarded = gd[pick];
  assign bus_addr    = ad[pick];
  assign bus_tag     = tg[pick];
  assign wi          = cnt - CW'(pop);
  assign cnt_n       = cnt + CW'(push) - CW'(pop);

  always_comb begin
    int src;
    for (int k = 0; k < DEPTH; k++) begin
      src = (pop && k >= int'(pick) && k < DEPTH - 1) ? k + 1 : k;
      kd_n[k] = kd[src];
      gd_n[k] = gd[src];
      ad_n[k] = ad[src];
      tg_n[k] = tg[src];
      if (push && CW'(k) == wi) begin
        kd_n[k] = req_kind;
        gd_n[k] = req_guarded;
        ad_n[k] = req_addr;
        tg_n[k] = req_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        kd[k] <= K_LD;
        gd[k] <= 1'b0;
        ad[k] <= '0;
        tg[k] <= '0;
      end
    end else begin
      cnt <= cnt_n;
      for (int k = 0; k < DEPTH; k++) begin
        kd[k] <= kd_n[k];
        gd[k] <= gd_n[k];
        ad[k] <= ad_n[k];
        tg[k] <= tg_n[k];
      end
    end
  end
endmodule

// File: rtl/guarded_order_queue_chk.sv
module guarded_order_queue_chk #(
  parameter int DEPTH = 8,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          bus_valid,
  input logic          bus_store,
  input logic          bus_ld_ready,
  input logic          bus_st_ready,
  input logic [CW-1:0] cnt,
  input logic          pop
);
  // R1
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == '0 |-> req_ready && !bus_valid);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R2
  accept_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !pop |=> cnt == $past(cnt) + 1'b1);
  // R11
  store_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_store |-> bus_st_ready);
  // R11
  load_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_store |-> bus_ld_ready);
  // R11
  issue_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> cnt != '0);
endmodule

bind guarded_order_queue guarded_order_queue_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/guarded_order_queue_tb_top.sv
module guarded_order_queue_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_guarded = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [31:0] req_addr = '0;
  logic [7:0] req_tag = '0;
  logic bus_ld_ready = 1'b0, bus_st_ready = 1'b0;
  logic bus_valid, bus_store, bus_guarded;
  logic [31:0] bus_addr;
  logic [7:0] bus_tag;

  int checks = 0, fails = 0, issued = 0;
  int exp_tag[$];
  bit exp_st[$];
  string exp_req[$];

  always #4 clk = ~clk;

  guarded_order_queue dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gran(input int g, input int off);
    return 32'(g * 8 + off);
  endfunction

  task automatic push_op(input logic [1:0] k, input logic g, input logic [31:0] a, input logic [7:0] t);
    logic r;
    @(posedge clk); #1;
    req_valid = 1'b1; req_kind = k; req_guarded = g; req_addr = a; req_tag = t;
    forever begin
      @(negedge clk); r = req_ready;
      @(posedge clk);
      if (r) break;
    end
    #1 req_valid = 1'b0;
  endtask

  task automatic expect_op(input int t, input bit st, input string req);
    exp_tag.push_back(t); exp_st.push_back(st); exp_req.push_back(req);
  endtask

  task automatic run_phase(input logic ld, input logic st, input int n, input int want, input string req);
    int n0;
    @(posedge clk); #1;
    bus_ld_ready = ld; bus_st_ready = st;
    n0 = issued;
    repeat (n) @(posedge clk);
    #1 bus_ld_ready = 1'b0; bus_st_ready = 1'b0;
    chk(issued - n0 == want, req, issued - n0, want);
  endtask

  task automatic drained(input string req);
    chk(exp_tag.size() == 0, req, exp_tag.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_valid) begin
      issued++;
      if (exp_tag.size() == 0) begin
        chk(1'b0, "R8/R11 unexpected issue", int'(bus_tag), -1);
      end else begin
        int t; bit s; string r;
        t = exp_tag.pop_front(); s = exp_st.pop_front(); r = exp_req.pop_front();
        chk(int'(bus_tag) == t && bus_store == s, r, int'(bus_tag), t);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(bus_valid == 1'b0, "R1 idle", int'(bus_valid), 0);

    // S1: passing, overlap stall, guarded load order, store after load
    push_op(2'd1, 1'b1, gran(1, 0), 8'd11);
    push_op(2'd0, 1'b1, gran(2, 4), 8'd12);
    push_op(2'd0, 1'b1, gran(1, 6), 8'd13);
    push_op(2'd0, 1'b1, gran(3, 0), 8'd14);
    push_op(2'd1, 1'b0, gran(4, 0), 8'd15);
    expect_op(12, 0, "R6 load passes store");
    run_phase(1'b1, 1'b0, 6, 1, "R7/R3 loads held");
    expect_op(11, 1, "R6 store order");
    expect_op(13, 0, "R7 overlap load after store");
    expect_op(14, 0, "R3 guarded load order");
    expect_op(15, 1, "R5 store after loads");
    run_phase(1'b1, 1'b1, 10, 4, "R5 drain S1");
    drained("R6 S1 drained");

    // S2: barrier fences group of guarded stores
    push_op(2'd1, 1'b1, gran(1, 0), 8'd21);
    push_op(2'd1, 1'b1, gran(2, 0), 8'd22);
    push_op(2'd2, 1'b0, gran(0, 0), 8'd23);
    push_op(2'd0, 1'b1, gran(5, 0), 8'd24);
    push_op(2'd0, 1'b0, gran(6, 0), 8'd25);
    expect_op(25, 0, "R10 ordinary load passes barrier");
    run_phase(1'b1, 1'b0, 6, 1, "R8 guarded load fenced");
    expect_op(21, 1, "R9 store group");
    expect_op(22, 1, "R9 store group");
    expect_op(24, 0, "R8 load after barrier");
    run_phase(1'b1, 1'b1, 10, 3, "R8 barrier not on bus");
    drained("R9 S2 drained");

    // S3: store waits for older load; stores in order
    push_op(2'd0, 1'b0, gran(1, 0), 8'd31);
    push_op(2'd1, 1'b1, gran(2, 0), 8'd32);
    push_op(2'd1, 1'b0, gran(3, 0), 8'd33);
    run_phase(1'b0, 1'b1, 5, 0, "R5 store behind load");
    expect_op(31, 0, "R11 load lane");
    run_phase(1'b1, 1'b0, 5, 1, "R11 load lane only");
    expect_op(32, 1, "R4 store order");
    expect_op(33, 1, "R4 store order");
    run_phase(1'b0, 1'b1, 5, 2, "R4 stores drain");
    drained("R4 S3 drained");

    // S4: ordinary load passes blocked guarded load; ordinary overlap waits
    push_op(2'd1, 1'b1, gran(1, 0), 8'd41);
    push_op(2'd0, 1'b1, gran(1, 2), 8'd42);
    push_op(2'd0, 1'b0, gran(7, 0), 8'd43);
    push_op(2'd1, 1'b0, gran(8, 0), 8'd44);
    push_op(2'd0, 1'b0, gran(8, 4), 8'd45);
    expect_op(43, 0, "R10 passes guarded load");
    run_phase(1'b1, 1'b0, 6, 1, "R7 ordinary overlap held");
    expect_op(41, 1, "R6 order");
    expect_op(42, 0, "R7 order");
    expect_op(44, 1, "R5 order");
    expect_op(45, 0, "R7 order");
    run_phase(1'b1, 1'b1, 10, 4, "R7 drain S4");
    drained("R10 S4 drained");

    // S5: full queue backpressure
    for (int i = 0; i < 8; i++) push_op(2'd0, 1'b0, gran(i, 0), 8'(50 + i));
    @(negedge clk);
    chk(req_ready == 1'b0, "R2 full", int'(req_ready), 0);
    for (int i = 0; i < 9; i++) expect_op(50 + i, 0, "R2 fifo order");
    fork
      push_op(2'd0, 1'b0, gran(9, 0), 8'd58);
      run_phase(1'b1, 1'b0, 20, 9, "R2 ninth accepted");
    join
    drained("R2 drained");
    @(negedge clk);
    chk(req_ready == 1'b1 && bus_valid == 1'b0, "R1 empty again", int'(req_ready), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule